// File: doc/BRIEF.md
# SMI Capability Handshake and Dispatch Unit

This block settles, once per reset, which system-management-interrupt capabilities the firmware may use. The platform presents the capabilities it supports as a feature mask. Firmware builds its request one byte at a time in a request register, then pulses a commit strobe. The block checks the request against the offered mask and the rules that link the features. If the request passes, the block copies it into the agreed mask and raises a done flag. The agreed mask and the flag then stay frozen until the next reset. A rejected request leaves the flag low, so firmware may correct the request and commit again.

The block also decodes writes to the power-management command port. Two reserved command bytes produce one-cycle pulses that switch the ACPI mode on or off. Any other byte raises an SMI, but only while the SMI-on-command enable input is high. When the broadcast capability has been agreed, the SMI goes to every CPU. Otherwise it goes only to the CPU that wrote the byte. A separate output flags a platform mask that offers CPU removal without CPU addition.

Top module: `smi_negotiator`

## Requirements
- R1: While reset is asserted and after it, the request register, the agreed mask, the done flag, the SMI lines and both ACPI pulses are all zero.
- R2: A byte write with lane index k sets bits [8k+7:8k] of the request register to the written byte and leaves all other bits unchanged. The request register is visible on `req_feat` one cycle after the write.
- R3: A commit whose request has any bit set that is clear in `host_feat` is rejected. The done flag stays 0 and the agreed mask stays 0.
- R4: A commit requesting CPU addition (bit 1) or CPU removal (bit 2) while broadcast (bit 0) is clear is rejected.
- R5: A commit requesting CPU removal (bit 2) without CPU addition (bit 1) is rejected.
- R6: A commit of a valid request copies the request into `neg_feat` and sets `feat_ok`, both visible one cycle after the strobe. An empty request is valid.
- R7: Once `feat_ok` is 1, later commits and later request writes leave `feat_ok` and `neg_feat` unchanged until reset.
- R8: A command byte equal to ACPI_ON_CMD (default 0xE1) or ACPI_OFF_CMD (default 0x1E) pulses `acpi_on` or `acpi_off` for one cycle, one cycle after the write, and raises no SMI.
- R9: A command byte that is neither ACPI command raises no SMI while `smi_apm_en` is 0.
- R10: A non-ACPI command byte written with `smi_apm_en` at 1 pulses `smi_req` for one cycle, one cycle after the write. All CPU lines pulse if agreed bit 0 is set; otherwise only line `apm_cpu` pulses.
- R11: `host_cfg_bad` is 1, combinationally, exactly when `host_feat` has bit 2 set and bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_feat | input | FEAT_W | Capabilities offered by the platform |
| host_cfg_bad | output | 1 | Offered mask has removal without addition |
| req_wr | input | 1 | Request-register byte write strobe |
| req_lane | input | $clog2(FEAT_W/8) | Byte lane index of the write |
| req_byte | input | 8 | Byte data to write |
| req_feat | output | FEAT_W | Current request register |
| commit | input | 1 | Commit strobe for the request |
| feat_ok | output | 1 | Handshake done, mask locked |
| neg_feat | output | FEAT_W | Agreed capability mask |
| apm_wr | input | 1 | Command port write strobe |
| apm_data | input | 8 | Command byte |
| apm_cpu | input | $clog2(CPU_N) | Index of the writing CPU |
| smi_apm_en | input | 1 | SMI-on-command enable |
| smi_req | output | CPU_N | One-cycle SMI pulse per CPU |
| acpi_on | output | 1 | One-cycle ACPI-enable pulse |
| acpi_off | output | 1 | One-cycle ACPI-disable pulse |

## Verification
A lock that fails to hold would show one cycle after a second commit, as a change on `neg_feat`. A wrong validation verdict shows one cycle after the commit, as a done flag that disagrees with the rule set. A stale or wrong agreed broadcast bit shows at the next non-ACPI command, as an SMI pattern that is one-hot where it should be all-ones, or the reverse. A misdecoded command shows as an SMI pulse and an ACPI pulse in the same cycle.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;

    // Capability bit positions shared by validator and dispatcher
    localparam int unsigned CAP_BCAST  = 0;
    localparam int unsigned CAP_ADD    = 1;
    localparam int unsigned CAP_REMOVE = 2;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_ACPI_ON  = 2'd1,
        CMD_ACPI_OFF = 2'd2,
        CMD_SMI      = 2'd3
    } apm_cmd_e;

endpackage

// File: rtl/smi_req_reg.sv
module smi_req_reg #(
    parameter int unsigned FEAT_W = 64,
    localparam int unsigned LANES  = FEAT_W / 8,
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [7:0]        wr_byte,
    output logic [FEAT_W-1:0] req_q
);
    typedef struct packed {
        logic [FEAT_W-1:0] req;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = wr_en && (wr_lane == LANE_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < LANES; b++) begin
            if (lane_hit[b]) begin
                st_d.req[8*b +: 8] = wr_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;
endmodule

// File: rtl/smi_feat_check.sv
module smi_feat_check
    import smi_neg_pkg::*;
#(
    parameter int unsigned FEAT_W = 64
) (
    input  logic [FEAT_W-1:0] host_feat,
    input  logic [FEAT_W-1:0] req_feat,
    output logic              req_valid,
    output logic              host_bad
);
    logic outside_host;
    logic needs_bcast;
    logic remove_alone;

    always_comb begin
        outside_host = |(req_feat & ~host_feat);
        needs_bcast  = (req_feat[CAP_ADD] || req_feat[CAP_REMOVE]) && !req_feat[CAP_BCAST];
        remove_alone = req_feat[CAP_REMOVE] && !req_feat[CAP_ADD];
        req_valid    = !outside_host && !needs_bcast && !remove_alone;
        host_bad     = host_feat[CAP_REMOVE] && !host_feat[CAP_ADD];
    end
endmodule

// File: rtl/smi_dispatch.sv
module smi_dispatch
    import smi_neg_pkg::*;
#(
    parameter int unsigned CPU_N    = 4,
    parameter logic [7:0]  ON_CMD   = 8'hE1,
    parameter logic [7:0]  OFF_CMD  = 8'h1E,
    localparam int unsigned CPU_IW  = (CPU_N > 1) ? $clog2(CPU_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apm_wr,
    input  logic [7:0]        apm_data,
    input  logic [CPU_IW-1:0] apm_cpu,
    input  logic              smi_en,
    input  logic              bcast,
    output logic [CPU_N-1:0]  smi_req,
    output logic              acpi_on,
    output logic              acpi_off
);
    typedef struct packed {
        logic [CPU_N-1:0] smi;
        logic             on;
        logic             off;
    } disp_state_t;

    disp_state_t st_d, st_q;
    apm_cmd_e    cmd;
    logic [CPU_N-1:0] target;

    always_comb begin
        cmd = CMD_NONE;
        if (apm_wr) begin
            if (apm_data == ON_CMD) begin
                cmd = CMD_ACPI_ON;
            end else if (apm_data == OFF_CMD) begin
                cmd = CMD_ACPI_OFF;
            end else if (smi_en) begin
                cmd = CMD_SMI;
            end
        end
    end

    for (genvar c = 0; c < CPU_N; c++) begin : g_cpu
        assign target[c] = bcast || (apm_cpu == CPU_IW'(c));
    end

    always_comb begin
        st_d     = '0;
        st_d.on  = (cmd == CMD_ACPI_ON);
        st_d.off = (cmd == CMD_ACPI_OFF);
        if (cmd == CMD_SMI) begin
            st_d.smi = target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smi_req  = st_q.smi;
    assign acpi_on  = st_q.on;
    assign acpi_off = st_q.off;
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
    import smi_neg_pkg::*;
#(
    parameter int unsigned FEAT_W  = 64,
    parameter int unsigned CPU_N   = 4,
    parameter logic [7:0]  ON_CMD  = 8'hE1,
    parameter logic [7:0]  OFF_CMD = 8'h1E,
    localparam int unsigned LANE_W = (FEAT_W / 8 > 1) ? $clog2(FEAT_W / 8) : 1,
    localparam int unsigned CPU_IW = (CPU_N > 1) ? $clog2(CPU_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FEAT_W-1:0] host_feat,
    output logic              host_cfg_bad,
    input  logic              req_wr,
    input  logic [LANE_W-1:0] req_lane,
    input  logic [7:0]        req_byte,
    output logic [FEAT_W-1:0] req_feat,
    input  logic              commit,
    output logic              feat_ok,
    output logic [FEAT_W-1:0] neg_feat,
    input  logic              apm_wr,
    input  logic [7:0]        apm_data,
    input  logic [CPU_IW-1:0] apm_cpu,
    input  logic              smi_apm_en,
    output logic [CPU_N-1:0]  smi_req,
    output logic              acpi_on,
    output logic              acpi_off
);
    typedef struct packed {
        logic              ok;
        logic [FEAT_W-1:0] neg;
    } lock_state_t;

    lock_state_t st_d, st_q;
    logic        req_valid;

    smi_req_reg #(.FEAT_W(FEAT_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_wr),
        .wr_lane (req_lane),
        .wr_byte (req_byte),
        .req_q   (req_feat)
    );

    smi_feat_check #(.FEAT_W(FEAT_W)) u_check (
        .host_feat (host_feat),
        .req_feat  (req_feat),
        .req_valid (req_valid),
        .host_bad  (host_cfg_bad)
    );

    always_comb begin
        st_d = st_q;
        if (commit && !st_q.ok && req_valid) begin
            st_d.ok  = 1'b1;
            st_d.neg = req_feat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign feat_ok  = st_q.ok;
    assign neg_feat = st_q.neg;

    smi_dispatch #(
        .CPU_N   (CPU_N),
        .ON_CMD  (ON_CMD),
        .OFF_CMD (OFF_CMD)
    ) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .apm_wr   (apm_wr),
        .apm_data (apm_data),
        .apm_cpu  (apm_cpu),
        .smi_en   (smi_apm_en),
        .bcast    (st_q.neg[CAP_BCAST]),
        .smi_req  (smi_req),
        .acpi_on  (acpi_on),
        .acpi_off (acpi_off)
    );
endmodule

// File: rtl/smi_negotiator_chk.sv
module smi_negotiator_chk #(
    parameter int unsigned FEAT_W = 64,
    parameter int unsigned CPU_N  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              feat_ok,
    input logic [FEAT_W-1:0] neg_feat,
    input logic              apm_wr,
    input logic              smi_apm_en,
    input logic [CPU_N-1:0]  smi_req,
    input logic              acpi_on,
    input logic              acpi_off
);
    AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |=> feat_ok); // R7
    AST_NEG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |=> $stable(neg_feat)); // R7
    AST_OK_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(feat_ok) |-> $past(commit)); // R6
    AST_NEG_ZERO_BEFORE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_ok |-> (neg_feat == '0)); // R3
    AST_NO_SMI_ON_ACPI: assert property (@(posedge clk) disable iff (!rst_n)
        (acpi_on || acpi_off) |-> (smi_req == '0)); // R8
    AST_ACPI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acpi_on && acpi_off)); // R8
    AST_SMI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|smi_req) |-> $past(apm_wr && smi_apm_en)); // R9
    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_feat[0] |-> $onehot0(smi_req)); // R10
endmodule

bind smi_negotiator smi_negotiator_chk #(.FEAT_W(FEAT_W), .CPU_N(CPU_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .feat_ok    (feat_ok),
    .neg_feat   (neg_feat),
    .apm_wr     (apm_wr),
    .smi_apm_en (smi_apm_en),
    .smi_req    (smi_req),
    .acpi_on    (acpi_on),
    .acpi_off   (acpi_off)
);

// File: tb/smi_negotiator_test.sv
`timescale 1ns/1ps
module smi_negotiator_test;
    localparam int FW = 64;
    localparam int CN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] host_feat = '0;
    logic          host_cfg_bad;
    logic          req_wr = 1'b0;
    logic [2:0]    req_lane = '0;
    logic [7:0]    req_byte = '0;
    logic [FW-1:0] req_feat;
    logic          commit = 1'b0;
    logic          feat_ok;
    logic [FW-1:0] neg_feat;
    logic          apm_wr = 1'b0;
    logic [7:0]    apm_data = '0;
    logic [1:0]    apm_cpu = '0;
    logic          smi_apm_en = 1'b0;
    logic [CN-1:0] smi_req;
    logic          acpi_on;
    logic          acpi_off;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smi_negotiator uut (
        .clk(clk), .rst_n(rst_n), .host_feat(host_feat), .host_cfg_bad(host_cfg_bad),
        .req_wr(req_wr), .req_lane(req_lane), .req_byte(req_byte), .req_feat(req_feat),
        .commit(commit), .feat_ok(feat_ok), .neg_feat(neg_feat),
        .apm_wr(apm_wr), .apm_data(apm_data), .apm_cpu(apm_cpu), .smi_apm_en(smi_apm_en),
        .smi_req(smi_req), .acpi_on(acpi_on), .acpi_off(acpi_off)
    );

    localparam int NV = 8;
    localparam logic [63:0] V_HOST [NV] = '{
        64'h7, 64'h7, 64'h1, 64'h7, 64'h7, 64'h7, 64'h8000_0000_0000_0007, 64'h7 };
    localparam logic [63:0] V_REQ [NV] = '{
        64'h7, 64'h0, 64'h3, 64'h2, 64'h5, 64'h3, 64'h8000_0000_0000_0001, 64'h100 };
    localparam bit V_OK [NV] = '{ 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0 };
    localparam string V_TAG [NV] = '{ "R6", "R6", "R3", "R4", "R5", "R6", "R6", "R3" };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_byte(input int lane, input logic [7:0] b);
        @(negedge clk);
        req_wr = 1'b1; req_lane = 3'(lane); req_byte = b;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic wr_req(input logic [63:0] v);
        for (int k = 0; k < 8; k++) wr_byte(k, v[8*k +: 8]);
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic apm(input logic [7:0] d, input logic [1:0] cpu, input logic en,
                       input string tag, input logic [3:0] exp_smi,
                       input logic exp_on, input logic exp_off);
        @(negedge clk);
        apm_wr = 1'b1; apm_data = d; apm_cpu = cpu; smi_apm_en = en;
        @(negedge clk);
        apm_wr = 1'b0;
        check({tag, " smi"}, 64'(smi_req), 64'(exp_smi));
        check({tag, " on"}, 64'(acpi_on), 64'(exp_on));
        check({tag, " off"}, 64'(acpi_off), 64'(exp_off));
        @(negedge clk);
        check({tag, " pulse end"}, 64'({smi_req, acpi_on, acpi_off}), 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: state during and after reset
        repeat (2) @(negedge clk);
        check("R1 ok in reset", 64'(feat_ok), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req", req_feat, 64'h0);
        check("R1 neg", neg_feat, 64'h0);
        check("R1 pulses", 64'({smi_req, acpi_on, acpi_off, feat_ok}), 64'h0);

        // Negotiation table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            host_feat = V_HOST[i];
            wr_req(V_REQ[i]);
            do_commit();
            check({V_TAG[i], " ok"}, 64'(feat_ok), 64'(V_OK[i]));
            check({V_TAG[i], " neg"}, neg_feat, V_OK[i] ? V_REQ[i] : 64'h0);
        end

        // R2: single lane write
        do_reset();
        wr_byte(3, 8'hAB);
        check("R2 lane3", req_feat, 64'h0000_0000_AB00_0000);
        wr_byte(7, 8'h5C);
        check("R2 lane7", req_feat, 64'h5C00_0000_AB00_0000);

        // R3 then retry: rejected commit, corrected request accepted
        do_reset();
        host_feat = 64'h7;
        wr_req(64'h10);
        do_commit();
        check("R3 reject", 64'(feat_ok), 64'h0);
        wr_req(64'h1);
        do_commit();
        check("R6 retry ok", 64'(feat_ok), 64'h1);
        check("R6 retry neg", neg_feat, 64'h1);

        // R7: lock holds against new writes and commits
        wr_req(64'h7);
        check("R7 req writable", req_feat, 64'h7);
        do_commit();
        check("R7 neg locked", neg_feat, 64'h1);
        check("R7 ok held", 64'(feat_ok), 64'h1);

        // R10 broadcast agreed: all CPUs
        apm(8'h55, 2'd2, 1'b1, "R10 bcast", 4'hF, 1'b0, 1'b0);
        // R8 ACPI commands
        apm(8'hE1, 2'd1, 1'b1, "R8 on", 4'h0, 1'b1, 1'b0);
        apm(8'h1E, 2'd1, 1'b1, "R8 off", 4'h0, 1'b0, 1'b1);

        // No broadcast agreed: only the writer
        do_reset();
        host_feat = 64'h7;
        do_commit();
        check("R6 empty ok", 64'(feat_ok), 64'h1);
        apm(8'h55, 2'd2, 1'b1, "R10 single", 4'b0100, 1'b0, 1'b0);
        apm(8'h00, 2'd3, 1'b1, "R10 single cpu3", 4'b1000, 1'b0, 1'b0);
        apm(8'h55, 2'd2, 1'b0, "R9 disabled", 4'h0, 1'b0, 1'b0);
        apm(8'h1E, 2'd0, 1'b0, "R8 off no en", 4'h0, 1'b0, 1'b1);

        // R11 host configuration flag
        host_feat = 64'h4;
        #1 check("R11 bad", 64'(host_cfg_bad), 64'h1);
        host_feat = 64'h6;
        #1 check("R11 good", 64'(host_cfg_bad), 64'h0);
        host_feat = 64'h5;
        #1 check("R11 bad bc", 64'(host_cfg_bad), 64'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule